// File: doc/BRIEF.md
# Word recognizer trigger unit

This block decides when a logic acquisition should be triggered. On every cycle where the sampler presents a new sample, it compares the sample with a programmed pattern. The sample is the 16-bit data word with one external qualifier bit placed above it. A separate care mask decides, bit by bit, whether that bit must equal the pattern or is ignored. A matching sample produces a one-cycle match pulse. The same pulse leaves the block on a dedicated pin, so that other instruments can start on the same condition.

A 2-bit source select chooses which event may trigger the acquisition:
- the external trigger input,
- a rising transition of data bit 0 between consecutive samples,
- the word recognizer becoming true,
- a manual request.

Every source is edge-qualified, so a condition that stays true produces only one event. The unit must be armed before it can fire. It fires once, emits a one-cycle trigger pulse to the acquisition controller, and then stays disarmed until it is armed again.

Top module: `wt_trigger_top`

## Requirements
- R1: The compared word is {qual_i, data_i}, with the qualifier at bit 16. When smp_en_i is high at a clock edge, match_o is high for the following cycle exactly when every compared bit with pat_care_i=1 equals the same bit of pat_val_i.
- R2: A bit with pat_care_i=0 does not affect match_o, whatever its data value. This also holds for the qualifier (bit 16).
- R3: When smp_en_i is low at an edge, match_o is low in the following cycle. The history used by the channel 0 and word sources is also left unchanged at that edge.
- R4: match_pin_o always carries the same value as match_o.
- R5: With src_sel_i=2'b00, a low-to-high change of ext_trig_i between consecutive clock edges is a trigger event. A level that stays high gives no further event.
- R6: With src_sel_i=2'b01, a sample whose bit 0 is 1 is a trigger event when the previous enabled sample had bit 0 equal to 0.
- R7: With src_sel_i=2'b10, a matching sample is a trigger event when the previous enabled sample did not match.
- R8: With src_sel_i=2'b11, a low-to-high change of man_req_i is a trigger event. A request held high for many cycles yields exactly one trigger pulse.
- R9: An event at an edge where the unit is armed makes trig_o high for exactly the next cycle and disarms the unit. While disarmed, events give no trigger. A high arm_i at an edge arms the unit from the next edge on.
- R10: After reset, match_o, match_pin_o and trig_o are low and the unit is disarmed. The stored previous values of ext_trig_i, man_req_i, data bit 0 and the recognizer result all read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arms the unit for one trigger |
| smp_en_i | input | 1 | A new sample is present on data_i / qual_i |
| data_i | input | 16 | Sampled data word |
| qual_i | input | 1 | External qualifier bit, compared as bit 16 |
| ext_trig_i | input | 1 | External trigger input |
| man_req_i | input | 1 | Manual trigger request (level) |
| pat_val_i | input | 17 | Required value per compared bit |
| pat_care_i | input | 17 | 1 = bit is compared, 0 = ignored |
| src_sel_i | input | 2 | Trigger source: 00 ext, 01 ch0, 10 word, 11 manual |
| match_o | output | 1 | Recognizer match pulse |
| match_pin_o | output | 1 | Copy of the match pulse for the external pin |
| trig_o | output | 1 | Trigger pulse to the acquisition controller |

## Verification
Every path has a single register stage. A wrong mask or compare bit therefore shows up as a wrong match_o one cycle after the sample that exposes it.

Faults in the edge-history registers or in the arm flag are quieter. They show as a trigger pulse that is missing, repeated or unexpected, one cycle after the event. They appear only when a held level, a repeated match or a second event is presented while disarmed. The stimulus therefore repeats each event and holds each level for several cycles, and checks trig_o on every one of those cycles.

// File: rtl/wt_pkg.sv
package wt_pkg;
   typedef enum logic [1:0] {
      SRC_EXT  = 2'b00,
      SRC_CH0  = 2'b01,
      SRC_WORD = 2'b10,
      SRC_MAN  = 2'b11
   } src_e;
endpackage

// File: rtl/wt_matcher.sv
// Masked equality compare, one slice per bit.
module wt_matcher #(
   parameter int W = 17
) (
   input  logic [W-1:0] word_i,
   input  logic [W-1:0] val_i,
   input  logic [W-1:0] care_i,
   output logic         hit_o
);
   logic [W-1:0] miss;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign miss[b] = care_i[b] & (word_i[b] ^ val_i[b]);
   end

   assign hit_o = ~|miss;
endmodule

// File: rtl/wt_rise.sv
// Rising-edge detector whose history advances only when en_i is high.
module wt_rise #(
   parameter bit GATED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic d_i,
   output logic rise_o
);
   logic q;
   logic step;

   if (GATED) begin : g_gated
      assign step = en_i;
   end else begin : g_free
      assign step = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (step) q <= d_i;
   end

   assign rise_o = step & d_i & ~q;
endmodule

// File: rtl/wt_arm_ctl.sv
// Source selection, arm flag and trigger pulse register.
module wt_arm_ctl
   import wt_pkg::*;
#(
   parameter int SRC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic [SRC_W-1:0] src_i,
   input  logic             ev_ext_i,
   input  logic             ev_ch0_i,
   input  logic             ev_word_i,
   input  logic             ev_man_i,
   output logic             armed_o,
   output logic             trig_o
);
   logic ev_sel;
   logic fire;

   always_comb begin
      unique case (src_e'(src_i))
         SRC_EXT:  ev_sel = ev_ext_i;
         SRC_CH0:  ev_sel = ev_ch0_i;
         SRC_WORD: ev_sel = ev_word_i;
         SRC_MAN:  ev_sel = ev_man_i;
         default:  ev_sel = 1'b0;
      endcase
   end

   assign fire = armed_o & ev_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_o <= 1'b0;
         trig_o  <= 1'b0;
      end else begin
         armed_o <= arm_i | (armed_o & ~fire);
         trig_o  <= fire;
      end
   end
endmodule

// File: rtl/wt_trigger_top.sv
module wt_trigger_top
   import wt_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CH0_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              smp_en_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              qual_i,
   input  logic              ext_trig_i,
   input  logic              man_req_i,
   input  logic [DATA_W:0]   pat_val_i,
   input  logic [DATA_W:0]   pat_care_i,
   input  logic [1:0]        src_sel_i,
   output logic              match_o,
   output logic              match_pin_o,
   output logic              trig_o
);
   localparam int PAT_W = DATA_W + 1;

   if (DATA_W < 1 || CH0_BIT < 0 || CH0_BIT >= DATA_W) begin : g_bad_param
      $error("wt_trigger_top: DATA_W must be >= 1 and CH0_BIT inside the data word");
   end

   logic [PAT_W-1:0] word;
   logic hit, ev_ext, ev_ch0, ev_word, ev_man, armed;

   assign word = {qual_i, data_i};

   wt_matcher #(.W(PAT_W)) u_match (
      .word_i(word), .val_i(pat_val_i), .care_i(pat_care_i), .hit_o(hit)
   );

   wt_rise #(.GATED(1'b0)) u_ext (
      .clk(clk), .rst_n(rst_n), .en_i(1'b1), .d_i(ext_trig_i), .rise_o(ev_ext)
   );
   wt_rise #(.GATED(1'b0)) u_man (
      .clk(clk), .rst_n(rst_n), .en_i(1'b1), .d_i(man_req_i), .rise_o(ev_man)
   );
   wt_rise #(.GATED(1'b1)) u_ch0 (
      .clk(clk), .rst_n(rst_n), .en_i(smp_en_i), .d_i(data_i[CH0_BIT]), .rise_o(ev_ch0)
   );
   wt_rise #(.GATED(1'b1)) u_word (
      .clk(clk), .rst_n(rst_n), .en_i(smp_en_i), .d_i(hit), .rise_o(ev_word)
   );

   wt_arm_ctl #(.SRC_W(2)) u_ctl (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .src_i(src_sel_i),
      .ev_ext_i(ev_ext), .ev_ch0_i(ev_ch0), .ev_word_i(ev_word), .ev_man_i(ev_man),
      .armed_o(armed), .trig_o(trig_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_o <= 1'b0;
      else        match_o <= smp_en_i & hit;
   end

   assign match_pin_o = match_o;
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
   parameter int DATA_W  = 16,
   parameter int CH0_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm_i,
   input logic              smp_en_i,
   input logic [DATA_W-1:0] data_i,
   input logic              qual_i,
   input logic              ext_trig_i,
   input logic              man_req_i,
   input logic [DATA_W:0]   pat_val_i,
   input logic [DATA_W:0]   pat_care_i,
   input logic [1:0]        src_sel_i,
   input logic              match_o,
   input logic              match_pin_o,
   input logic              trig_o,
   input logic              armed
);
   logic eq;
   assign eq = ((({qual_i, data_i} ^ pat_val_i) & pat_care_i) == '0);

   // R1, R2
   a_r1_hit: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en_i && eq |=> match_o);
   a_r1_miss: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en_i && !eq |=> !match_o);
   a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en_i |=> !match_o);
   a_r4_pin: assert property (@(posedge clk) disable iff (!rst_n)
      match_pin_o == match_o);
   a_r5_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel_i == 2'b00 && !ext_trig_i |=> !trig_o);
   a_r6_ch0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel_i == 2'b01 && !(smp_en_i && data_i[CH0_BIT]) |=> !trig_o);
   a_r7_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel_i == 2'b10 && !smp_en_i |=> !trig_o);
   a_r8_man_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel_i == 2'b11 && !man_req_i |=> !trig_o);
   a_r9_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !trig_o);
   a_r9_arm: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> armed);
endmodule

bind wt_trigger_top wt_checker #(.DATA_W(DATA_W), .CH0_BIT(CH0_BIT)) u_wt_chk (
   .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .smp_en_i(smp_en_i), .data_i(data_i),
   .qual_i(qual_i), .ext_trig_i(ext_trig_i), .man_req_i(man_req_i),
   .pat_val_i(pat_val_i), .pat_care_i(pat_care_i), .src_sel_i(src_sel_i),
   .match_o(match_o), .match_pin_o(match_pin_o), .trig_o(trig_o), .armed(armed)
);

// File: tb/test_wt_trigger_top.sv
`timescale 1ns/100ps
module test_wt_trigger_top;
   logic clk = 1'b0;
   logic rst_n, arm, smp_en, qual, ext, man;
   logic [15:0] data;
   logic [16:0] pval, pcare;
   logic [1:0]  src;
   logic match, match_pin, trig;
   int n_chk = 0, n_bad = 0;
   int pulses;

   always #2.5 clk = ~clk;

   wt_trigger_top i_wt_trigger_top (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .smp_en_i(smp_en), .data_i(data),
      .qual_i(qual), .ext_trig_i(ext), .man_req_i(man), .pat_val_i(pval),
      .pat_care_i(pcare), .src_sel_i(src), .match_o(match),
      .match_pin_o(match_pin), .trig_o(trig)
   );

   // {pattern, care, {qual,data}, expected match}
   localparam logic [51:0] VEC [8] = '{
      {17'h1A5A5, 17'h1FFFF, 17'h1A5A5, 1'b1},
      {17'h1A5A5, 17'h1FFFF, 17'h1A5A4, 1'b0},
      {17'h1A5A5, 17'h0FFFF, 17'h0A5A5, 1'b1},
      {17'h1A5A5, 17'h1FFFF, 17'h0A5A5, 1'b0},
      {17'h00000, 17'h00000, 17'h01234, 1'b1},
      {17'h00030, 17'h000F0, 17'h0FF3F, 1'b1},
      {17'h00030, 17'h000F0, 17'h0FF2F, 1'b0},
      {17'h18000, 17'h18000, 17'h18000, 1'b1}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse_arm();
      arm = 1'b1; smp_en = 1'b0; tick(); arm = 1'b0;
      chk("R9 no trig on arm cycle", trig, 1'b0);
   endtask

   task automatic sample(input logic [15:0] d, input logic q);
      data = d; qual = q; smp_en = 1'b1; tick(); smp_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; arm = 0; smp_en = 0; qual = 0; ext = 0; man = 0;
      data = '0; pval = '0; pcare = '0; src = 2'b10;
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      chk("R10 match_o reset", match, 1'b0);
      chk("R10 pin reset", match_pin, 1'b0);
      chk("R10 trig_o reset", trig, 1'b0);

      // R1 / R2 / R4: vector walk, unit disarmed
      foreach (VEC[i]) begin
         pval = VEC[i][51:35]; pcare = VEC[i][34:18];
         sample(VEC[i][16:1], VEC[i][17]);
         chk("R1 R2 vector match", match, VEC[i][0]);
         chk("R4 pin follows match", match_pin, VEC[i][0]);
         chk("R9 disarmed no trig", trig, 1'b0);
      end

      // R3: matching word without sample enable
      pval = 17'h0BEEF; pcare = 17'h1FFFF;
      data = 16'hBEEF; qual = 1'b0; smp_en = 1'b0; tick();
      chk("R3 no match without enable", match, 1'b0);

      // R7 word source
      src = 2'b10;
      sample(16'h0000, 1'b0);
      pulse_arm();
      sample(16'hBEEF, 1'b0);
      chk("R7 word trig on first match", trig, 1'b1);
      chk("R1 match pulse", match, 1'b1);
      tick();
      chk("R9 trig one cycle", trig, 1'b0);
      pulse_arm();
      sample(16'hBEEF, 1'b0);
      chk("R7 held match no retrigger", trig, 1'b0);
      sample(16'h0001, 1'b0);
      pulse_arm();
      data = 16'hBEEF; tick();
      chk("R3 unsampled match no trig", trig, 1'b0);
      sample(16'hBEEF, 1'b0);
      chk("R7 rearmed match trig", trig, 1'b1);
      sample(16'h0000, 1'b0);
      sample(16'hBEEF, 1'b0);
      chk("R9 disarmed after fire", trig, 1'b0);

      // R5 external source
      src = 2'b00;
      pulse_arm();
      ext = 1'b1; tick();
      chk("R5 ext rising trig", trig, 1'b1);
      tick();
      chk("R5 ext held no retrigger", trig, 1'b0);
      pulse_arm();
      tick();
      chk("R5 ext level no trig", trig, 1'b0);
      ext = 1'b0; tick();
      ext = 1'b1; tick();
      chk("R5 ext second edge trig", trig, 1'b1);
      ext = 1'b0;

      // R6 channel 0 source
      src = 2'b01;
      pulse_arm();
      sample(16'h0000, 1'b0);
      chk("R6 bit0 low no trig", trig, 1'b0);
      data = 16'h0001; tick();
      chk("R3 unsampled bit0 no trig", trig, 1'b0);
      sample(16'h0001, 1'b0);
      chk("R6 bit0 rise trig", trig, 1'b1);
      pulse_arm();
      sample(16'hFFFF, 1'b0);
      chk("R6 bit0 held high no trig", trig, 1'b0);
      sample(16'hFFFE, 1'b0);
      sample(16'h0003, 1'b0);
      chk("R6 second rise trig", trig, 1'b1);

      // R8 manual source
      src = 2'b11;
      pulse_arm();
      man = 1'b1; pulses = 0;
      for (int k = 0; k < 4; k++) begin
         tick();
         if (trig) pulses++;
      end
      chk("R8 one pulse per press", pulses == 1, 1'b1);
      pulse_arm();
      tick();
      chk("R8 held request no trig", trig, 1'b0);
      man = 1'b0; tick();
      man = 1'b1; tick();
      chk("R8 new press trig", trig, 1'b1);
      man = 1'b0;

      // R10: reset mid-run clears outputs and arm state
      pulse_arm();
      rst_n = 1'b0; tick(); rst_n = 1'b1;
      man = 1'b1; tick();
      chk("R10 reset disarms", trig, 1'b0);
      chk("R10 match low after reset", match, 1'b0);
      man = 1'b0;

      finish_run();
   end
endmodule